// File: doc/BRIEF.md
# Receive Interrupt Event Generator

This block sits beside a receive data path that writes frame bytes into host buffers and turns the path's strobes into receive interrupts. A per-byte deposit strobe drives a per-frame byte counter. When early receive is enabled and that counter reaches a programmable header-size threshold, the block raises an early event. Every completed frame raises a frame-received event. If a frame is dropped for lack of buffers, a not-ready event is raised, but only for the first such frame until software re-arms the latch.

The three events set sticky status bits. The block ORs these bits into one interrupt line. Software clears them by writing ones to an acknowledge word. With early receive enabled, each frame gives two events: an early one and a final one. Software cannot mask either of them on its own.

Top module: `rx_irq_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `irq_status` is 0 and `irq` is 0.
- R2: A `frame_end` strobe sets status bit 1 (frame received) at the clock edge that samples it.
- R3: With `early_en` high, status bit 0 (early) is set at the edge that samples the `byte_strobe` that brings the frame's byte count to a value at or above `hdr_thresh`. A threshold of 0 fires on the first byte.
- R4: The early event fires at most once per frame. A `frame_end` or `frame_drop` restarts the byte count at 0 and re-enables the early event for the next frame.
- R5: With `early_en` low, status bit 0 is never set, whatever the byte count.
- R6: Suppose the byte that reaches the threshold arrives in the same cycle as `frame_end`. Then bits 0 and 1 are both set at that same edge.
- R7: Status bit 2 (receive not ready) is set by the first `frame_drop` after reset or after a re-arm. Later drops do not set it again.
- R8: A `res_restart` pulse re-arms the not-ready latch. If `res_restart` and `frame_drop` come together while the latch is disarmed, no event fires and the latch is armed afterwards.
- R9: Status bits are sticky. With `ack_wr` high, each bit k with `ack_data[k]` = 1 is cleared. If an event for bit k arrives in the same cycle, the event wins and the bit stays set.
- R10: `irq` equals the OR of the three status bits in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_strobe | input | 1 | One byte of the current frame was deposited |
| frame_end | input | 1 | Current frame fully written to memory |
| frame_drop | input | 1 | Current frame lost for lack of resources |
| early_en | input | 1 | Enables the early (header) event |
| hdr_thresh | input | CNT_W | Byte count that triggers the early event |
| res_restart | input | 1 | Software signals resources available; re-arms not-ready |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_data | input | 3 | Write-one-to-clear mask: bit0 early, bit1 frame, bit2 not-ready |
| irq_status | output | 3 | Sticky status: bit0 early, bit1 frame, bit2 not-ready |
| irq | output | 1 | OR of all status bits |

## Verification
The bench sends frames that end exactly on the threshold byte. A design that moved the early event one byte late, or lost it when the frame ended, would set only the frame bit there. It also sends very long frames that pass the threshold by a wide margin. A counter that fired again on every byte past the threshold would show a new early bit after each acknowledge. Back-to-back drops, and a re-arm that lands in the same cycle as a drop, expose a not-ready latch that is level-sensitive or lets the drop win. An acknowledge that coincides with a fresh event shows whether a clear-priority design silently loses interrupts.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int NUM_EV   = 3;
  localparam int EV_EARLY = 0;
  localparam int EV_FRAME = 1;
  localparam int EV_NORES = 2;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/rx_byte_counter.sv
module rx_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_strobe,
  input  logic             frame_close,
  input  logic             early_en,
  input  logic [CNT_W-1:0] hdr_thresh,
  output logic             early_ev
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] cnt_sat;

  // widened add so saturation at the top code is exact
  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign cnt_sat = (cnt_inc > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : cnt_inc[CNT_W-1:0];

  always_comb begin
    early_ev = 1'b0;
    if (early_en && byte_strobe && !fired_q && (cnt_inc >= {1'b0, hdr_thresh}))
      early_ev = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (frame_close) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (byte_strobe) cnt_q <= cnt_sat;
      if (early_ev)    fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_nores_latch.sv
module rx_nores_latch (
  input  logic clk,
  input  logic rst,
  input  logic frame_drop,
  input  logic res_restart,
  output logic nores_ev
);
  logic armed_q;

  assign nores_ev = frame_drop && armed_q;

  always_ff @(posedge clk) begin
    if (rst)              armed_q <= 1'b1;
    else if (res_restart) armed_q <= 1'b1;
    else if (frame_drop)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         ack_wr,
  input  logic [N-1:0] ack_data,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] st_next;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_comb begin
      st_next[k] = status[k];
      if (ack_wr && ack_data[k]) st_next[k] = 1'b0;
      if (set_ev[k])             st_next[k] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_next;
      irq    <= |st_next;
    end
  end
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import rx_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_strobe,
  input  logic              frame_end,
  input  logic              frame_drop,
  input  logic              early_en,
  input  logic [CNT_W-1:0]  hdr_thresh,
  input  logic              res_restart,
  input  logic              ack_wr,
  input  logic [NUM_EV-1:0] ack_data,
  output logic [NUM_EV-1:0] irq_status,
  output logic              irq
);
  ev_vec_t ev_vec;
  logic    early_ev;
  logic    nores_ev;

  rx_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .byte_strobe (byte_strobe),
    .frame_close (frame_end | frame_drop),
    .early_en    (early_en),
    .hdr_thresh  (hdr_thresh),
    .early_ev    (early_ev)
  );

  rx_nores_latch u_nores (
    .clk         (clk),
    .rst         (rst),
    .frame_drop  (frame_drop),
    .res_restart (res_restart),
    .nores_ev    (nores_ev)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_EARLY] = early_ev;
    ev_vec[EV_FRAME] = frame_end;
    ev_vec[EV_NORES] = nores_ev;
  end

  rx_irq_status #(.N(NUM_EV)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_ev   (ev_vec),
    .ack_wr   (ack_wr),
    .ack_data (ack_data),
    .status   (irq_status),
    .irq      (irq)
  );
endmodule

// File: rtl/rx_irq_gen_chk.sv
module rx_irq_gen_chk
  import rx_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              early_en,
  input logic              res_restart,
  input logic              ack_wr,
  input logic [NUM_EV-1:0] ack_data,
  input logic [NUM_EV-1:0] ev_vec,
  input logic [NUM_EV-1:0] irq_status,
  input logic              irq
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_status == '0 && !irq));

  p_irq_is_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq == (|irq_status));

  p_no_early_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    !early_en |-> !ev_vec[EV_EARLY]);

  p_nores_once_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_vec[EV_NORES] && !res_restart) |=> !ev_vec[EV_NORES]);

  p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ev_vec[EV_FRAME] |=> irq_status[EV_FRAME]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_status[EV_NORES] && !(ack_wr && ack_data[EV_NORES])) |=> irq_status[EV_NORES]);
endmodule

bind rx_irq_gen rx_irq_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .early_en    (early_en),
  .res_restart (res_restart),
  .ack_wr      (ack_wr),
  .ack_data    (ack_data),
  .ev_vec      (ev_vec),
  .irq_status  (irq_status),
  .irq         (irq)
);

// File: tb/sim_rx_irq_gen.sv
`timescale 1ns/1ps
module sim_rx_irq_gen;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_strobe = 0, frame_end = 0, frame_drop = 0, early_en = 0;
  logic res_restart = 0, ack_wr = 0;
  logic [CNT_W-1:0] hdr_thresh = '0;
  logic [2:0] ack_data = '0;
  logic [2:0] irq_status;
  logic irq;

  always #10 clk = ~clk; // 50 MHz

  rx_irq_gen #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .byte_strobe(byte_strobe), .frame_end(frame_end),
    .frame_drop(frame_drop), .early_en(early_en), .hdr_thresh(hdr_thresh),
    .res_restart(res_restart), .ack_wr(ack_wr), .ack_data(ack_data),
    .irq_status(irq_status), .irq(irq));

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t sb_q[$];

  int n_cmp = 0, n_bad = 0;
  // reference model state
  logic [2:0] m_st = '0;
  int m_cnt = 0;
  bit m_fired = 0, m_armed = 1;

  task automatic cmp(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got irq/status=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input bit be, fe, fd, rr, aw, input logic [2:0] ad, input string tag);
    item_t it;
    bit e_ev, n_ev;
    @(negedge clk);
    byte_strobe = be; frame_end = fe; frame_drop = fd;
    res_restart = rr; ack_wr = aw; ack_data = ad;
    e_ev = early_en && be && !m_fired && ((m_cnt + 1) >= int'(hdr_thresh));
    n_ev = fd && m_armed;
    if (fe || fd) begin m_cnt = 0; m_fired = 0; end
    else begin m_cnt = m_cnt + (be ? 1 : 0); m_fired = m_fired | e_ev; end
    if (rr) m_armed = 1; else if (fd) m_armed = 0;
    m_st = (m_st & ~(aw ? ad : 3'b000)) | {n_ev, fe, e_ev};
    it.exp = {|m_st, m_st};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 3'b000, tag);
  endtask

  task automatic ack_all(input string tag);
    step(0, 0, 0, 0, 1, 3'b111, tag);
  endtask

  // monitor: sample 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      cmp({irq, irq_status}, it.exp, it.tag);
    end
  end

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 cmp({irq, irq_status}, 4'b0000, "R1 reset state");
    @(negedge clk) rst = 0;
    @(posedge clk); #5 cmp({irq, irq_status}, 4'b0000, "R1 after reset");

    // R2 plain frame, early off; R5 many bytes, no early
    early_en = 0; hdr_thresh = 4;
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, 3'b000, "R5 early off");
    step(1, 1, 0, 0, 0, 3'b000, "R2 frame end");
    idle("R10 irq held");
    ack_all("R9 ack clears");

    // R3 threshold 4, early on; R4 once per frame
    early_en = 1;
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 3'b000, "R3 early at threshold");
    ack_all("R9 ack early");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 3'b000, "R4 no re-fire");
    step(0, 1, 0, 0, 0, 3'b000, "R2 final event");
    ack_all("R9 ack");

    // R4 second frame fires again; R6 end on threshold byte
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 3'b000, "R4 below threshold");
    step(1, 1, 0, 0, 0, 3'b000, "R6 early and frame same edge");
    ack_all("R9 ack");

    // R3 threshold 0 fires on first byte
    hdr_thresh = 0;
    step(1, 0, 0, 0, 0, 3'b000, "R3 threshold zero");
    step(1, 1, 0, 0, 0, 3'b000, "R4 once");
    ack_all("R9 ack");

    // R9 set wins over ack in same cycle
    hdr_thresh = 2;
    step(1, 0, 0, 0, 0, 3'b000, "R3 one byte");
    step(1, 0, 0, 0, 1, 3'b001, "R9 event beats clear");
    step(0, 1, 0, 0, 1, 3'b011, "R9 frame beats clear");
    step(0, 0, 0, 0, 1, 3'b010, "R9 partial clear");
    ack_all("R9 ack");

    // R4 drop closes frame too
    hdr_thresh = 3;
    step(1, 0, 0, 0, 0, 3'b000, "R4 partial frame");
    step(1, 0, 0, 0, 0, 3'b000, "R4 partial frame");
    step(0, 0, 1, 0, 0, 3'b000, "R7 first drop");
    step(1, 0, 0, 0, 0, 3'b000, "R4 count restarted");
    step(1, 0, 0, 0, 0, 3'b000, "R4 count restarted");
    ack_all("R9 ack");

    // R7 later drops silent
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 3'b000, "R7 repeated drop silent");
    idle("R7 silent");
    // R8 restart then drop
    step(0, 0, 0, 1, 0, 3'b000, "R8 restart");
    step(0, 0, 1, 0, 0, 3'b000, "R8 drop after restart");
    ack_all("R9 ack");
    // R8 restart with drop while disarmed
    step(0, 0, 1, 1, 0, 3'b000, "R8 coincident restart");
    step(0, 0, 1, 0, 0, 3'b000, "R8 armed after coincident");
    step(0, 0, 1, 0, 1, 3'b100, "R9 ack then silent drop");
    idle("R10 idle");

    // R5 early disabled mid traffic with threshold 1
    early_en = 0; hdr_thresh = 1;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 3'b000, "R5 early off");
    step(0, 1, 0, 0, 0, 3'b000, "R2 frame end");
    ack_all("R10 all clear");
    idle("R10 idle low");

    // R1 reset mid operation
    step(1, 1, 0, 0, 0, 3'b000, "R2 before reset");
    @(negedge clk) rst = 1; byte_strobe = 0; frame_end = 0;
    @(posedge clk); #5 cmp({irq, irq_status}, 4'b0000, "R1 reset in service");
    @(negedge clk) rst = 0;
    m_st = '0; m_cnt = 0; m_fired = 0; m_armed = 1;
    step(0, 0, 1, 0, 0, 3'b000, "R7 rearmed by reset");
    idle("R10 final");

    @(posedge clk); #6;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule